// File: doc/BRIEF.md
# Issue-Stage Latency Interlock

This block guards the issue point of a single-issue, in-order pipeline. Each cycle the decoder offers one instruction on a valid/ready stream. The instruction carries its class, an optional destination register and up to two source registers. Each register is tagged as integer or floating point, and a flag marks source B as the data operand of a store. The block keeps a per-register countdown of how many more cycles each outstanding result needs. It withholds `in_ready` until every source of the offered instruction has waited long enough for the class that produced it and for the way the consumer uses it.

A producer's wait is counted in gap cycles after its issue. Independent instructions issued in between use up that gap, so a scheduler that reorders code sees fewer bubbles. Integer and FP registers are held in two separate scoreboards. Integer register 0 is a constant and is never busy. A free-running counter records how many cycles an offered instruction was held.

Back-pressure rules: an instruction is accepted on a cycle with `in_valid` and `in_ready` both high, and `issue` pulses on that cycle. `in_ready` depends only on the offered fields and the scoreboard, never on `in_valid`. Upstream may hold, change or withdraw an instruction that has not been accepted. Such an instruction leaves no mark on the scoreboard.

Top module: `issue_interlock`

## Requirements
- R1: A synchronous active-high `rst` clears every scoreboard entry and `stall_cnt`. After reset any instruction is accepted at once.
- R2: The result of a load (class 0) holds any dependent instruction until one gap cycle has passed, so back-to-back issue costs 1 bubble.
- R3: An FP add (class 4) result costs 3 bubbles for a general consumer. It costs 2 when the consumer is a store (class 1) reading it on source B with `in_b_sdata`=1.
- R4: An FP multiply (class 5) result costs 5 bubbles for a general consumer and 4 for store data. `in_b_sdata` on a non-store, or a store's B source with `in_b_sdata`=0, counts as a general consumer.
- R5: An integer ALU (class 2) result costs 1 bubble before a branch (class 3) and none before any other consumer.
- R6: Each instruction issued between producer and consumer reduces the bubbles by one. A load/add/store/decrement/branch/nop loop takes 10 cycles in source order and 6 cycles when reordered.
- R7: Integer and FP registers with the same index are independent. Integer register 0 as a destination never delays a reader.
- R8: `stall` = `in_valid` and not `in_ready`, and `issue` = `in_valid` and `in_ready`. An instruction that is not accepted loads no scoreboard entry.
- R9: `stall_cnt` rises by one on every cycle `stall` is high, saturating at all ones, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Offered instruction is valid |
| in_ready | output | 1 | Offered instruction may issue this cycle |
| in_class | input | 3 | 0 load, 1 store, 2 integer ALU, 3 branch, 4 FP add, 5 FP multiply |
| in_dst | input | IDX_W | Destination register index |
| in_dst_fp | input | 1 | Destination is in the FP file |
| in_dst_we | input | 1 | Instruction writes a destination |
| in_a_idx | input | IDX_W | Source A register index |
| in_a_fp | input | 1 | Source A is in the FP file |
| in_a_use | input | 1 | Source A is read |
| in_b_idx | input | IDX_W | Source B register index |
| in_b_fp | input | 1 | Source B is in the FP file |
| in_b_use | input | 1 | Source B is read |
| in_b_sdata | input | 1 | Source B is a store's data operand |
| stall | output | 1 | Offered instruction is held this cycle |
| issue | output | 1 | Offered instruction is accepted this cycle |
| stall_cnt | output | STALL_W | Count of held cycles |

## Verification
The bench measures bubbles per producer class and consumer role. A table that ignored the consumer role would show 3 or 5 bubbles instead of 2 or 4 on store data, or one bubble instead of none for an integer result used as an address. Two whole loop schedules are timed, which catches a countdown that starts one cycle late or ignores intervening instructions. A held-then-withdrawn instruction is followed at once by a reader of its destination, so a scoreboard written while stalled shows up as a spurious bubble. Same-index registers in the two files, integer register 0, and a reset that lands while results are in flight are each checked.

// File: rtl/interlock_pkg.sv
package interlock_pkg;

  typedef enum logic [2:0] {
    CL_LOAD   = 3'd0,
    CL_STORE  = 3'd1,
    CL_IALU   = 3'd2,
    CL_BRANCH = 3'd3,
    CL_FADD   = 3'd4,
    CL_FMUL   = 3'd5
  } iclass_e;

  // How the producer of a pending result relaxes the wait per consumer role.
  typedef enum logic [1:0] {
    PK_NONE    = 2'd0,
    PK_ANY     = 2'd1,  // every consumer waits the full gap
    PK_BRONLY  = 2'd2,  // only branches wait
    PK_FPRELAX = 2'd3   // store data waits a shorter gap
  } pkind_e;

  function automatic pkind_e kind_of(iclass_e c);
    case (c)
      CL_LOAD:          return PK_ANY;
      CL_IALU:          return PK_BRONLY;
      CL_FADD, CL_FMUL: return PK_FPRELAX;
      default:          return PK_NONE;
    endcase
  endfunction

  function automatic logic has_result(iclass_e c);
    return (c == CL_LOAD) || (c == CL_IALU) || (c == CL_FADD) || (c == CL_FMUL);
  endfunction

endpackage

// File: rtl/interlock_scoreboard.sv
module interlock_scoreboard
  import interlock_pkg::*;
#(
  parameter int IDX_W    = 5,
  parameter int CNT_W    = 3,
  parameter int NRD      = 2,
  parameter bit PIN_ZERO = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [CNT_W-1:0]           wr_cnt,
  input  pkind_e                     wr_kind,
  input  logic [NRD-1:0][IDX_W-1:0]  rd_idx,
  output logic [NRD-1:0][CNT_W-1:0]  rd_cnt,
  output pkind_e [NRD-1:0]           rd_kind
);
  localparam int NREG = 1 << IDX_W;
  localparam int KW   = 2;

  logic [NREG*CNT_W-1:0] cnt_flat;
  logic [NREG*KW-1:0]    kind_flat;

  for (genvar e = 0; e < NREG; e++) begin : g_ent
    if (PIN_ZERO && e == 0) begin : g_pin
      assign cnt_flat[e*CNT_W +: CNT_W] = '0;
      assign kind_flat[e*KW +: KW]      = PK_NONE;
    end else begin : g_live
      logic [CNT_W-1:0] c_q;
      pkind_e           k_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          c_q <= '0;
          k_q <= PK_NONE;
        end else if (wr_en && wr_idx == IDX_W'(e)) begin
          c_q <= wr_cnt;
          k_q <= wr_kind;
        end else if (c_q != '0) begin
          c_q <= c_q - 1'b1;
        end
      end
      assign cnt_flat[e*CNT_W +: CNT_W] = c_q;
      assign kind_flat[e*KW +: KW]      = k_q;
    end
  end

  always_comb begin
    for (int r = 0; r < NRD; r++) begin
      rd_cnt[r]  = cnt_flat[rd_idx[r]*CNT_W +: CNT_W];
      rd_kind[r] = pkind_e'(kind_flat[rd_idx[r]*KW +: KW]);
    end
  end

endmodule

// File: rtl/interlock_hazard.sv
module interlock_hazard
  import interlock_pkg::*;
#(
  parameter int CNT_W        = 3,
  parameter int SDATA_RELIEF = 1
) (
  input  logic             src_use,
  input  pkind_e           src_kind,
  input  logic [CNT_W-1:0] src_remain,
  input  logic             consumer_branch,
  input  logic             as_sdata,
  output logic             hold
);
  logic             exempt;
  logic [CNT_W-1:0] allowed;

  always_comb begin
    exempt  = 1'b0;
    allowed = '0;
    case (src_kind)
      PK_BRONLY:  exempt = !consumer_branch;
      PK_FPRELAX: if (as_sdata) allowed = CNT_W'(SDATA_RELIEF);
      default:    allowed = '0;
    endcase
    hold = src_use && !exempt && (src_remain > allowed);
  end

endmodule

// File: rtl/interlock_stall_counter.sv
module interlock_stall_counter #(
  parameter int STALL_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inc,
  output logic [STALL_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)                       count <= '0;
    else if (inc && count != '1)   count <= count + 1'b1;
  end
endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
  import interlock_pkg::*;
#(
  parameter int IDX_W        = 5,
  parameter int STALL_W      = 16,
  parameter int LOAD_GAP     = 1,
  parameter int IALU_BR_GAP  = 1,
  parameter int FADD_GAP     = 3,
  parameter int FMUL_GAP     = 5,
  parameter int SDATA_RELIEF = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [2:0]         in_class,
  input  logic [IDX_W-1:0]   in_dst,
  input  logic               in_dst_fp,
  input  logic               in_dst_we,
  input  logic [IDX_W-1:0]   in_a_idx,
  input  logic               in_a_fp,
  input  logic               in_a_use,
  input  logic [IDX_W-1:0]   in_b_idx,
  input  logic               in_b_fp,
  input  logic               in_b_use,
  input  logic               in_b_sdata,
  output logic               stall,
  output logic               issue,
  output logic [STALL_W-1:0] stall_cnt
);
  localparam int GAP_A   = (LOAD_GAP > IALU_BR_GAP) ? LOAD_GAP : IALU_BR_GAP;
  localparam int GAP_B   = (FADD_GAP > FMUL_GAP) ? FADD_GAP : FMUL_GAP;
  localparam int GAP_MAX = (GAP_A > GAP_B) ? GAP_A : GAP_B;
  localparam int CNT_W   = $clog2(GAP_MAX + 1);
  localparam int NSRC    = 2;

  iclass_e          cls;
  logic [CNT_W-1:0] dest_gap;
  pkind_e           dest_kind;
  logic             wr_int, wr_fp;
  logic [NSRC-1:0]  hold;

  logic [NSRC-1:0][IDX_W-1:0] rd_idx;
  logic [NSRC-1:0][CNT_W-1:0] int_cnt, fp_cnt;
  pkind_e [NSRC-1:0]          int_kind, fp_kind;

  assign cls       = iclass_e'(in_class);
  assign dest_kind = kind_of(cls);
  assign rd_idx    = {in_b_idx, in_a_idx};

  always_comb begin
    case (cls)
      CL_LOAD: dest_gap = CNT_W'(LOAD_GAP);
      CL_IALU: dest_gap = CNT_W'(IALU_BR_GAP);
      CL_FADD: dest_gap = CNT_W'(FADD_GAP);
      CL_FMUL: dest_gap = CNT_W'(FMUL_GAP);
      default: dest_gap = '0;
    endcase
  end

  assign wr_int = issue && in_dst_we && has_result(cls) && !in_dst_fp;
  assign wr_fp  = issue && in_dst_we && has_result(cls) &&  in_dst_fp;

  interlock_scoreboard #(
    .IDX_W(IDX_W), .CNT_W(CNT_W), .NRD(NSRC), .PIN_ZERO(1'b1)
  ) u_sb_int (
    .clk(clk), .rst(rst), .wr_en(wr_int), .wr_idx(in_dst), .wr_cnt(dest_gap),
    .wr_kind(dest_kind), .rd_idx(rd_idx), .rd_cnt(int_cnt), .rd_kind(int_kind)
  );

  interlock_scoreboard #(
    .IDX_W(IDX_W), .CNT_W(CNT_W), .NRD(NSRC), .PIN_ZERO(1'b0)
  ) u_sb_fp (
    .clk(clk), .rst(rst), .wr_en(wr_fp), .wr_idx(in_dst), .wr_cnt(dest_gap),
    .wr_kind(dest_kind), .rd_idx(rd_idx), .rd_cnt(fp_cnt), .rd_kind(fp_kind)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic             use_s, fp_s, sd_s;
    logic [CNT_W-1:0] rem_s;
    pkind_e           kind_s;

    assign use_s  = (s == 0) ? in_a_use : in_b_use;
    assign fp_s   = (s == 0) ? in_a_fp  : in_b_fp;
    assign sd_s   = (s == 1) && in_b_sdata && (cls == CL_STORE);
    assign rem_s  = fp_s ? fp_cnt[s]  : int_cnt[s];
    assign kind_s = fp_s ? fp_kind[s] : int_kind[s];

    interlock_hazard #(
      .CNT_W(CNT_W), .SDATA_RELIEF(SDATA_RELIEF)
    ) u_hz (
      .src_use(use_s), .src_kind(kind_s), .src_remain(rem_s),
      .consumer_branch(cls == CL_BRANCH), .as_sdata(sd_s), .hold(hold[s])
    );
  end

  assign in_ready = ~|hold;
  assign stall    = in_valid && !in_ready;
  assign issue    = in_valid && in_ready;

  interlock_stall_counter #(.STALL_W(STALL_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(stall), .count(stall_cnt)
  );

endmodule

// File: rtl/interlock_checker.sv
module interlock_checker #(
  parameter int IDX_W   = 5,
  parameter int STALL_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic [2:0]         in_class,
  input logic [IDX_W-1:0]   in_dst,
  input logic               in_dst_fp,
  input logic               in_dst_we,
  input logic [IDX_W-1:0]   in_a_idx,
  input logic               in_a_fp,
  input logic               in_a_use,
  input logic               in_b_use,
  input logic               stall,
  input logic               issue,
  input logic [STALL_W-1:0] stall_cnt
);
  p_cnt_cleared_r1: assert property (@(posedge clk) rst |=> stall_cnt == '0);

  p_stall_form_r8: assert property (@(posedge clk) disable iff (rst)
    stall |-> (in_valid && !in_ready));

  p_issue_form_r8: assert property (@(posedge clk) disable iff (rst)
    issue |-> (in_valid && in_ready));

  p_cnt_step_r9: assert property (@(posedge clk) disable iff (rst)
    (stall && stall_cnt != '1) |=> stall_cnt == STALL_W'($past(stall_cnt) + 1'b1));

  p_cnt_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !stall |=> $stable(stall_cnt));

  p_load_bubble_r2: assert property (@(posedge clk) disable iff (rst)
    (issue && in_class == 3'd0 && in_dst_we && (in_dst_fp || in_dst != '0))
    |=> (!(in_valid && in_a_use && in_a_fp == $past(in_dst_fp) && in_a_idx == $past(in_dst))
         || stall));

  p_fmul_bubble_r4: assert property (@(posedge clk) disable iff (rst)
    (issue && in_class == 3'd5 && in_dst_we && in_dst_fp)
    |=> (!(in_valid && in_a_use && in_a_fp && in_a_idx == $past(in_dst)) || stall));

  p_zero_free_r7: assert property (@(posedge clk) disable iff (rst)
    (in_a_use && !in_a_fp && in_a_idx == '0 && !in_b_use) |-> in_ready);

endmodule

bind issue_interlock interlock_checker #(.IDX_W(IDX_W), .STALL_W(STALL_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_class(in_class),
  .in_dst(in_dst), .in_dst_fp(in_dst_fp), .in_dst_we(in_dst_we), .in_a_idx(in_a_idx),
  .in_a_fp(in_a_fp), .in_a_use(in_a_use), .in_b_use(in_b_use), .stall(stall),
  .issue(issue), .stall_cnt(stall_cnt)
);

// File: tb/tb_issue_interlock.sv
`timescale 1ns/1ps
module tb_issue_interlock;
  localparam int C_LD = 0, C_ST = 1, C_IA = 2, C_BR = 3, C_FA = 4, C_FM = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_class = '0;
  logic [4:0] in_dst = '0, in_a_idx = '0, in_b_idx = '0;
  logic in_dst_fp = 0, in_dst_we = 0, in_a_fp = 0, in_a_use = 0;
  logic in_b_fp = 0, in_b_use = 0, in_b_sdata = 0;
  logic stall, issue;
  logic [15:0] stall_cnt;

  int checks = 0, errors = 0, exp_stalls = 0;

  always #2.5 clk = ~clk;

  issue_interlock dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_class(in_class),
    .in_dst(in_dst), .in_dst_fp(in_dst_fp), .in_dst_we(in_dst_we), .in_a_idx(in_a_idx),
    .in_a_fp(in_a_fp), .in_a_use(in_a_use), .in_b_idx(in_b_idx), .in_b_fp(in_b_fp),
    .in_b_use(in_b_use), .in_b_sdata(in_b_sdata), .stall(stall), .issue(issue),
    .stall_cnt(stall_cnt)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input int cls, input int d, input bit dfp, input bit dwe,
                       input int a, input bit afp, input bit ause,
                       input int b, input bit bfp, input bit buse, input bit bsd);
    in_class = 3'(cls); in_dst = 5'(d); in_dst_fp = dfp; in_dst_we = dwe;
    in_a_idx = 5'(a); in_a_fp = afp; in_a_use = ause;
    in_b_idx = 5'(b); in_b_fp = bfp; in_b_use = buse; in_b_sdata = bsd;
  endtask

  // Offer one instruction from a negedge; return the cycles it was held.
  task automatic push(input int cls, input int d, input bit dfp, input bit dwe,
                      input int a, input bit afp, input bit ause,
                      input int b, input bit bfp, input bit buse, input bit bsd,
                      output int bub);
    bub = 0;
    drive(cls, d, dfp, dwe, a, afp, ause, b, bfp, buse, bsd);
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      bub++;
      @(negedge clk); #1;
    end
    exp_stalls += bub;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1", "stall_cnt after reset", int'(stall_cnt), 0);
    drive(C_FA, 9, 1, 1, 9, 1, 1, 3, 1, 1, 0);
    in_valid = 1'b1; #1;
    check("R1", "ready on empty scoreboard", int'(in_ready), 1);
    check("R8", "issue strobe", int'(issue), 1);
    check("R8", "no stall", int'(stall), 0);
    in_valid = 1'b0;
    idle(1);
  endtask

  task automatic t_load;
    int b;
    push(C_LD, 0, 1, 1, 1, 0, 1, 0, 0, 0, 0, b);
    push(C_FA, 4, 1, 1, 0, 1, 1, 2, 1, 1, 0, b);
    check("R2", "load FP -> add", b, 1);
    idle(8);
    push(C_LD, 5, 0, 1, 1, 0, 1, 0, 0, 0, 0, b);
    push(C_IA, 6, 0, 1, 5, 0, 1, 0, 0, 0, 0, b);
    check("R2", "load int -> alu", b, 1);
    idle(8);
  endtask

  task automatic t_fadd;
    int b;
    push(C_FA, 4, 1, 1, 0, 1, 1, 2, 1, 1, 0, b);
    push(C_FA, 6, 1, 1, 4, 1, 1, 2, 1, 1, 0, b);
    check("R3", "fadd -> fadd", b, 3);
    idle(8);
    push(C_FA, 4, 1, 1, 0, 1, 1, 2, 1, 1, 0, b);
    push(C_ST, 0, 0, 0, 1, 0, 1, 4, 1, 1, 1, b);
    check("R3", "fadd -> store data", b, 2);
    idle(8);
  endtask

  task automatic t_fmul;
    int b;
    push(C_FM, 4, 1, 1, 0, 1, 1, 2, 1, 1, 0, b);
    push(C_FA, 6, 1, 1, 4, 1, 1, 2, 1, 1, 0, b);
    check("R4", "fmul -> fadd", b, 5);
    idle(8);
    push(C_FM, 4, 1, 1, 0, 1, 1, 2, 1, 1, 0, b);
    push(C_ST, 0, 0, 0, 1, 0, 1, 4, 1, 1, 1, b);
    check("R4", "fmul -> store data", b, 4);
    idle(8);
    push(C_FM, 4, 1, 1, 0, 1, 1, 2, 1, 1, 0, b);
    push(C_ST, 0, 0, 0, 1, 0, 1, 4, 1, 1, 0, b);
    check("R4", "fmul -> store B not data", b, 5);
    idle(8);
    push(C_FM, 4, 1, 1, 0, 1, 1, 2, 1, 1, 0, b);
    push(C_FA, 6, 1, 1, 2, 1, 1, 4, 1, 1, 1, b);
    check("R4", "sdata flag on non-store", b, 5);
    idle(8);
  endtask

  task automatic t_ialu;
    int b;
    push(C_IA, 1, 0, 1, 1, 0, 1, 0, 0, 0, 0, b);
    push(C_BR, 0, 0, 0, 1, 0, 1, 2, 0, 1, 0, b);
    check("R5", "alu -> branch", b, 1);
    idle(8);
    push(C_IA, 1, 0, 1, 1, 0, 1, 0, 0, 0, 0, b);
    push(C_LD, 0, 1, 1, 1, 0, 1, 0, 0, 0, 0, b);
    check("R5", "alu -> load base", b, 0);
    idle(8);
    push(C_IA, 1, 0, 1, 1, 0, 1, 0, 0, 0, 0, b);
    push(C_ST, 0, 0, 0, 1, 0, 1, 4, 1, 1, 1, b);
    check("R5", "alu -> store base", b, 0);
    idle(8);
  endtask

  task automatic t_reorder;
    int b, total;
    total = 0;
    push(C_LD, 0, 1, 1, 1, 0, 1, 0, 0, 0, 0, b); total += 1 + b;
    push(C_FA, 4, 1, 1, 0, 1, 1, 2, 1, 1, 0, b); total += 1 + b;
    push(C_ST, 0, 0, 0, 1, 0, 1, 4, 1, 1, 1, b); total += 1 + b;
    push(C_IA, 1, 0, 1, 1, 0, 1, 0, 0, 0, 0, b); total += 1 + b;
    push(C_BR, 0, 0, 0, 1, 0, 1, 2, 0, 1, 0, b); total += 1 + b;
    push(C_IA, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, b); total += 1 + b;
    check("R6", "source-order loop cycles", total, 10);
    idle(8);
    total = 0;
    push(C_LD, 0, 1, 1, 1, 0, 1, 0, 0, 0, 0, b); total += 1 + b;
    push(C_IA, 1, 0, 1, 1, 0, 1, 0, 0, 0, 0, b); total += 1 + b;
    push(C_FA, 4, 1, 1, 0, 1, 1, 2, 1, 1, 0, b); total += 1 + b;
    push(C_BR, 0, 0, 0, 1, 0, 1, 2, 0, 1, 0, b); total += 1 + b;
    push(C_ST, 0, 0, 0, 1, 0, 1, 4, 1, 1, 1, b); total += 1 + b;
    check("R6", "reordered loop cycles", total, 6);
    idle(8);
    push(C_FM, 4, 1, 1, 0, 1, 1, 2, 1, 1, 0, b);
    for (int i = 0; i < 3; i++) push(C_IA, 7 + i, 0, 1, 3, 0, 1, 0, 0, 0, 0, b);
    push(C_ST, 0, 0, 0, 1, 0, 1, 4, 1, 1, 1, b);
    check("R6", "fmul, 3 fillers, store data", b, 1);
    idle(8);
  endtask

  task automatic t_files;
    int b;
    push(C_LD, 3, 1, 1, 1, 0, 1, 0, 0, 0, 0, b);
    push(C_IA, 9, 0, 1, 3, 0, 1, 0, 0, 0, 0, b);
    check("R7", "FP F3 vs int R3", b, 0);
    idle(8);
    push(C_IA, 0, 0, 1, 1, 0, 1, 0, 0, 0, 0, b);
    push(C_BR, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0, b);
    check("R7", "int reg 0 never busy", b, 0);
    idle(8);
  endtask

  task automatic t_noaccept;
    int b;
    push(C_FM, 6, 1, 1, 0, 1, 1, 2, 1, 1, 0, b);
    drive(C_FA, 8, 1, 1, 6, 1, 1, 2, 1, 1, 0);
    in_valid = 1'b1;
    for (int i = 0; i < 2; i++) begin
      #1;
      check("R8", "held: stall", int'(stall), 1);
      check("R8", "held: issue", int'(issue), 0);
      exp_stalls++;
      @(negedge clk);
    end
    in_valid = 1'b0; #1;
    check("R8", "withdrawn: stall", int'(stall), 0);
    check("R8", "withdrawn: ready still low", int'(in_ready), 0);
    push(C_FA, 10, 1, 1, 8, 1, 1, 2, 1, 1, 0, b);
    check("R8", "withdrawn dest not marked", b, 0);
    idle(8);
  endtask

  task automatic t_counter;
    #1;
    check("R9", "stall_cnt total", int'(stall_cnt), exp_stalls);
    idle(3); #1;
    check("R9", "stall_cnt holds idle", int'(stall_cnt), exp_stalls);
  endtask

  task automatic t_reset_mid;
    int b;
    push(C_FM, 6, 1, 1, 0, 1, 1, 2, 1, 1, 0, b);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; #1;
    check("R1", "stall_cnt cleared", int'(stall_cnt), 0);
    push(C_FA, 8, 1, 1, 6, 1, 1, 2, 1, 1, 0, b);
    check("R1", "in-flight entry cleared", b, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load();
    t_fadd();
    t_fmul();
    t_ialu();
    t_reorder();
    t_files();
    t_noaccept();
    t_counter();
    t_reset_mid();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule